// File: doc/BRIEF.md
# SPI Controller with Two-Step Completion Clear

This block is an 8-bit serial peripheral interface engine behind a small register bus. Software sets it up through a control register. It then starts a byte by writing the data register. In master mode the block makes the serial clock from the system clock and shifts the byte out on its MOSI pin. At the same time it shifts the reply in from MISO. In slave mode it follows an external clock and an active-low select. It shifts the written byte out on MISO and collects the byte arriving on MOSI.

Each finished byte raises a completion flag, which can raise an interrupt request. The flag is not cleared by a plain write. Software first touches the status register while the flag is up, and then accesses the data register. Until the status read has happened, writes to the data register are dropped. A program that has not looked at the status therefore cannot overwrite the byte it has not yet collected.

Top module: `spi_hs_ctrl`

## Requirements
- R1: The register map has three addresses: 0 is data, 1 is control and 2 is status. In master mode, an accepted write to address 0 starts a transfer. The byte leaves on `mosi_out` most significant bit first.
- R2: After the eighth bit of a byte, the completion flag sets. This is status bit 7. A read of address 0 then returns the byte received during that transfer.
- R3: `irq` is high exactly when three things hold: the completion flag is set, control bit 2 (interrupt enable) is 1, and `irq_mask` is 0.
- R4: In master mode (control bit 1 = 1), the flag clears only when a status read made while the flag is set is followed by a data read. A data write, or a data read with no fresh status read, leaves the flag set. Each completed byte needs a new status read.
- R5: In slave mode (control bit 1 = 0), the flag clears when any status access made while the flag is set is followed by either a data read or a data write.
- R6: While the flag is set and no status read has happened since it was set, writes to address 0 are ignored and start no transfer.
- R7: Control bit 3 sets the idle level of the serial clock. With control bit 4 = 0, data is sampled on the leading clock edge. With control bit 4 = 1, data is sampled on the trailing edge.
- R8: Control bits 6:5 set the master bit rate. Codes 0 to 3 give a half period of 2, 4, 8 and 16 system clocks, which is division by 4, 8, 16 and 32. Each byte has exactly 16 clock edges.
- R9: Slave mode runs with control bit 0 = 1 and bit 1 = 0. Clock, select and MOSI are synchronised. The slave drives the last written byte on `miso_out`, most significant bit first, and stores the byte seen on `mosi_in`.
- R10: A high `ss_n_in` clears the slave bit counter and reloads the slave shift register, so a cut-off byte raises no flag. With phase 1 and select held low, the next written byte is reloaded after each byte ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_mask | input | 1 | CPU interrupt mask, 1 blocks `irq` |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Master serial clock |
| mosi_out | output | 1 | Master serial data out |
| miso_in | input | 1 | Master serial data in |
| sck_in | input | 1 | Slave serial clock from the external master |
| ss_n_in | input | 1 | Slave select, active low |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out |

## Verification
In master mode, MOSI is looped back to MISO. A table of bytes is then run through all four polarity and phase pairs and all four divider codes. The bench monitor samples MOSI on the edge that the phase setting names. A phase, bit-order or edge-count error therefore gives a different byte or edge count from the loopback readback. Bytes 00, FF and alternating patterns separate stuck and shifted bits.

Directed sequences drive the flag handshake in both modes. They check data-write lockout, the master rule that a write does not clear the flag, and the slave rule that a write does clear it. Slave tests run phase 0 with a select pulse per byte and phase 1 with select held low across two bytes. A last slave test drops select in the middle of a byte.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

  // register addresses
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  // control register image, packed from bit 6 down to bit 0
  typedef struct packed {
    logic [1:0] div;   // bits 6:5 bit-rate code
    logic       pha;   // bit 4 clock phase
    logic       pol;   // bit 3 clock idle level
    logic       ien;   // bit 2 interrupt enable
    logic       mst;   // bit 1 master select
    logic       en;    // bit 0 block enable
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // half period of the master clock in system clocks: 2, 4, 8, 16
  function automatic logic [4:0] half_period(input logic [1:0] code);
    return 5'd2 << code;
  endfunction

  // an edge is leading when the clock leaves its idle level
  function automatic logic edge_is_leading(input logic new_level, input logic pol);
    return new_level != pol;
  endfunction

endpackage

// File: rtl/spi_hs_regs.sv
module spi_hs_regs
  import spi_hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          done_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          irq_mask_i,
  output ctrl_t         ctrl_o,
  output logic          flag_o,
  output logic          armed_o,
  output logic          data_wr_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);

  ctrl_t ctrl_q;
  logic  flag_q, armed_q;

  // bus decode, brought out as named events
  logic stat_rd, stat_acc, data_rd, data_wr, ctrl_wr;
  logic arm_evt, clr_evt;

  assign stat_rd  = bus_rd && (bus_addr == A_STAT);
  assign stat_acc = (bus_rd || bus_wr) && (bus_addr == A_STAT);
  assign data_rd  = bus_rd && (bus_addr == A_DATA);
  assign data_wr  = bus_wr && (bus_addr == A_DATA);
  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);

  // master arms on a status read only; slave on any status access
  assign arm_evt  = flag_q && (ctrl_q.mst ? stat_rd : stat_acc);
  // master clears on a data read only; slave on a data read or write
  assign clr_evt  = flag_q && armed_q && (ctrl_q.mst ? data_rd : (data_rd || data_wr));

  assign data_wr_o = data_wr && ctrl_q.en && (!flag_q || armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (done_i) begin
        flag_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (clr_evt) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (arm_evt) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (bus_addr)
      A_DATA:  rdata_o = rx_byte_i;
      A_CTRL:  rdata_o = DW'(ctrl_q);
      A_STAT:  rdata_o[DW-1] = flag_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o   = flag_q && ctrl_q.ien && !irq_mask_i;
  assign ctrl_o  = ctrl_q;
  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  // R4 / R5: the flag only drops after the status step
  a_r5_clear_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(armed_o));

  // R4: a master data write never clears the flag
  a_r4_master_write_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mst && flag_q && data_wr && !data_rd) |=> flag_o);

  // R3: a set mask silences the request
  a_r3_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask_i |-> !irq_o);

endmodule

// File: rtl/spi_hs_clkgen.sv
module spi_hs_clkgen
  import spi_hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en_i,
  input  logic       start_i,
  input  logic       pol_i,
  input  logic [1:0] div_i,
  output logic       sck_o,
  output logic       lead_o,
  output logic       trail_o,
  output logic       finish_o,
  output logic       busy_o
);

  localparam int NEDGE = 2 * DW;
  localparam int EW    = $clog2(NEDGE + 1);

  logic [4:0]    hcnt;
  logic [EW-1:0] edges;
  logic          run, sck_q, tick;

  assign tick     = run && (hcnt == half_period(div_i) - 5'd1);
  assign lead_o   = tick && !edges[0];
  assign trail_o  = tick && edges[0];
  assign finish_o = trail_o && (edges == EW'(NEDGE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      hcnt  <= '0;
      edges <= '0;
      sck_q <= 1'b0;
    end else if (!run_en_i) begin
      run   <= 1'b0;
      hcnt  <= '0;
      edges <= '0;
      sck_q <= pol_i;
    end else if (!run) begin
      sck_q <= pol_i;
      hcnt  <= '0;
      edges <= '0;
      if (start_i) run <= 1'b1;
    end else if (tick) begin
      sck_q <= ~sck_q;
      hcnt  <= '0;
      edges <= edges + EW'(1);
      if (finish_o) run <= 1'b0;
    end else begin
      hcnt <= hcnt + 5'd1;
    end
  end

  assign sck_o  = sck_q;
  assign busy_o = run;

  // R8: after sixteen toggles the clock is back at its idle level
  a_r8_finish_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> (sck_o == $past(pol_i)));

endmodule

// File: rtl/spi_hs_sync.sv
module spi_hs_sync
  import spi_hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pol_i,
  input  logic sck_in,
  input  logic ss_n_in,
  input  logic mosi_in,
  output logic sel_o,
  output logic mosi_s_o,
  output logic lead_o,
  output logic trail_o
);

  localparam int NS = 3;
  localparam logic [NS-1:0] RST_VAL = 3'b010;   // select idles high

  logic [NS-1:0] raw, synced;
  logic          sck_d;

  assign raw = {mosi_in, ss_n_in, sck_in};

  // two-stage synchroniser per input line
  for (genvar g = 0; g < NS; g++) begin : g_sync
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST_VAL[g]}};
      else        st <= {st[0], raw[g]};
    end
    assign synced[g] = st[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= synced[0];
  end

  logic chg;
  assign chg      = (synced[0] != sck_d) && sel_o;
  assign sel_o    = !synced[1];
  assign mosi_s_o = synced[2];
  assign lead_o   = chg && edge_is_leading(synced[0], pol_i);
  assign trail_o  = chg && !edge_is_leading(synced[0], pol_i);

endmodule

// File: rtl/spi_hs_shifter.sv
module spi_hs_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          mst_i,
  input  logic          pha_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          m_busy_i,
  input  logic          m_lead_i,
  input  logic          m_trail_i,
  input  logic          m_finish_i,
  input  logic          s_sel_i,
  input  logic          s_lead_i,
  input  logic          s_trail_i,
  input  logic          miso_i,
  input  logic          mosi_s_i,
  output logic          start_o,
  output logic          tx_bit_o,
  output logic          done_o,
  output logic [DW-1:0] rx_byte_o
);

  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] txsr, txbuf, rxsr, rxbuf, rx_next;
  logic [CW-1:0] cnt;
  logic lead, trail, samp, shft, in_bit, s_end;

  assign lead    = mst_i ? m_lead_i  : s_lead_i;
  assign trail   = mst_i ? m_trail_i : s_trail_i;
  // phase 0 samples on leading edges, phase 1 on trailing edges
  assign samp    = en_i && (pha_i ? trail : lead);
  // phase 1 holds the first bit through the first leading edge
  assign shft    = en_i && (pha_i ? (lead && cnt != '0) : trail);
  assign in_bit  = mst_i ? miso_i : mosi_s_i;
  assign rx_next = {rxsr[DW-2:0], in_bit};
  assign s_end   = en_i && !mst_i && samp && (cnt == CW'(DW - 1));

  assign start_o = en_i && mst_i && load_i && !m_busy_i;
  assign done_o  = en_i && (mst_i ? m_finish_i : s_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsr  <= '0;
      txbuf <= '0;
      rxsr  <= '0;
      rxbuf <= '0;
      cnt   <= '0;
    end else begin
      if (load_i) txbuf <= wdata_i;

      if (start_o)
        txsr <= wdata_i;
      else if (!mst_i && (!s_sel_i || s_end))
        txsr <= load_i ? wdata_i : txbuf;
      else if (shft)
        txsr <= {txsr[DW-2:0], 1'b0};

      if (samp) rxsr <= rx_next;

      if (!en_i || start_o || (!mst_i && !s_sel_i) || done_o)
        cnt <= '0;
      else if (samp)
        cnt <= cnt + CW'(1);

      if (done_o) rxbuf <= samp ? rx_next : rxsr;
    end
  end

  assign tx_bit_o  = txsr[DW-1];
  assign rx_byte_o = rxbuf;

  // R2: the clock generator ends a byte exactly when eight bits were sampled
  a_r2_master_eight_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_i && m_finish_i) |-> ((cnt + CW'(samp)) == CW'(DW)));

  // R10: a deselected slave starts the next byte from bit zero
  a_r10_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !mst_i && !s_sel_i) |=> (cnt == '0));

endmodule

// File: rtl/spi_hs_ctrl.sv
module spi_hs_ctrl
  import spi_hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_mask,
  output logic          irq,
  output logic          sck_out,
  output logic          mosi_out,
  input  logic          miso_in,
  input  logic          sck_in,
  input  logic          ss_n_in,
  input  logic          mosi_in,
  output logic          miso_out
);

  ctrl_t         ctrl;
  logic          flag, armed, load, done, start, tx_bit;
  logic [DW-1:0] rx_byte;
  logic          m_busy, m_lead, m_trail, m_finish;
  logic          s_sel, s_mosi, s_lead, s_trail;

  spi_hs_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .done_i(done), .rx_byte_i(rx_byte), .irq_mask_i(irq_mask),
    .ctrl_o(ctrl), .flag_o(flag), .armed_o(armed), .data_wr_o(load),
    .rdata_o(bus_rdata), .irq_o(irq)
  );

  spi_hs_clkgen #(.DW(DW)) u_clkgen (
    .clk(clk), .rst_n(rst_n),
    .run_en_i(ctrl.en && ctrl.mst), .start_i(start),
    .pol_i(ctrl.pol), .div_i(ctrl.div),
    .sck_o(sck_out), .lead_o(m_lead), .trail_o(m_trail),
    .finish_o(m_finish), .busy_o(m_busy)
  );

  spi_hs_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pol_i(ctrl.pol),
    .sck_in(sck_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in),
    .sel_o(s_sel), .mosi_s_o(s_mosi), .lead_o(s_lead), .trail_o(s_trail)
  );

  spi_hs_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en_i(ctrl.en), .mst_i(ctrl.mst), .pha_i(ctrl.pha),
    .load_i(load), .wdata_i(bus_wdata),
    .m_busy_i(m_busy), .m_lead_i(m_lead), .m_trail_i(m_trail), .m_finish_i(m_finish),
    .s_sel_i(s_sel), .s_lead_i(s_lead), .s_trail_i(s_trail),
    .miso_i(miso_in), .mosi_s_i(s_mosi),
    .start_o(start), .tx_bit_o(tx_bit), .done_o(done), .rx_byte_o(rx_byte)
  );

  assign mosi_out = ctrl.en && ctrl.mst && tx_bit;
  assign miso_out = ctrl.en && !ctrl.mst && s_sel && tx_bit;

  // R6: a transfer never starts while an unread completion is pending
  a_r6_no_start_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_busy) |-> $past(!flag || armed));

endmodule

// File: tb/test_spi_hs_ctrl.sv
module test_spi_hs_ctrl;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_mask = 1'b0, irq;
  logic       sck_out, mosi_out, miso_out;
  logic       sck_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  spi_hs_ctrl i_spi_hs_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_mask(irq_mask), .irq(irq),
    .sck_out(sck_out), .mosi_out(mosi_out), .miso_in(mosi_out),
    .sck_in(sck_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in), .miso_out(miso_out)
  );

  // master-side monitor: samples MOSI on the edge the phase names
  logic       mon_pol = 1'b0, mon_pha = 1'b0, mon_clr = 1'b0, prev_sck = 1'b0;
  logic [7:0] mon_byte = 8'h00;
  int         mon_edges = 0, mon_gap = 0, last_t = 0, cyc = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      mon_byte  <= 8'h00;
      mon_edges <= 0;
    end else if (sck_out !== prev_sck) begin
      mon_edges <= mon_edges + 1;
      mon_gap   <= cyc - last_t;
      last_t    <= cyc;
      if ((sck_out != mon_pol) ^ mon_pha) mon_byte <= {mon_byte[6:0], mosi_out};
    end
    prev_sck <= sck_out;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] cval(input logic mst, ien, pol, pha, input logic [1:0] div);
    return {1'b0, div, pha, pol, ien, mst, 1'b1};
  endfunction

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim && !irq; i++) @(negedge clk);
  endtask

  task automatic clear_mon;
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  // bench acts as an external master, nbits clocks with select handled outside
  task automatic slave_bits(input logic pol, pha, input logic [7:0] tx, input int nbits,
                            output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!pha) begin
        mosi_in = tx[i];
        wait_cyc(HALF);
        sck_in = ~pol; rx = {rx[6:0], miso_out};
        wait_cyc(HALF);
        sck_in = pol;
      end else begin
        sck_in = ~pol; mosi_in = tx[i];
        wait_cyc(HALF);
        sck_in = pol; rx = {rx[6:0], miso_out};
        wait_cyc(HALF);
      end
    end
  endtask

  // {pol, pha, div, byte}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 1'b0, 2'd0, 8'hA5}, {1'b0, 1'b1, 2'd1, 8'h3C},
    {1'b1, 1'b0, 2'd2, 8'h81}, {1'b1, 1'b1, 2'd3, 8'h7E},
    {1'b0, 1'b0, 2'd3, 8'h00}, {1'b1, 1'b1, 2'd0, 8'hFF}};

  // watchdog
  initial begin
    wait_cyc(150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d, m1, m2;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // reset state
    rd(2'd1, d); chk("R1 reset ctrl", d, 8'h00);
    rd(2'd2, d); chk("R2 reset status", d, 8'h00);
    chk("R3 reset irq", irq, 1'b0);
    chk("R7 reset sck idle", sck_out, 1'b0);
    chk("R1 reset mosi", mosi_out, 1'b0);

    // master loopback table
    foreach (VEC[k]) begin
      logic pol, pha; logic [1:0] div; logic [7:0] b;
      {pol, pha, div, b} = VEC[k];
      mon_pol = pol; mon_pha = pha;
      wr(2'd1, cval(1'b1, 1'b1, pol, pha, div));
      wait_cyc(3);
      chk("R7 idle level", sck_out, pol);
      clear_mon();
      wr(2'd0, b);
      wait_irq(2000);
      wait_cyc(2);
      chk("R3 irq on completion", irq, 1'b1);
      chk("R1 R7 mosi byte as sampled", mon_byte, b);
      chk("R8 edge count", mon_edges, 16);
      chk("R8 half period", mon_gap, 32'd2 << div);
      rd(2'd2, d); chk("R2 flag set", d[7], 1'b1);
      rd(2'd0, d); chk("R2 loopback byte", d, b);
      rd(2'd2, d); chk("R4 flag cleared", d[7], 1'b0);
      chk("R3 irq dropped", irq, 1'b0);
    end

    // master handshake and write lockout
    mon_pol = 1'b0; mon_pha = 1'b0;
    wr(2'd1, cval(1'b1, 1'b1, 1'b0, 1'b0, 2'd0));
    wait_cyc(2);
    wr(2'd0, 8'h5A);
    wait_irq(500); wait_cyc(2);
    clear_mon();
    wr(2'd0, 8'hC3);
    wait_cyc(60);
    chk("R6 blocked write starts nothing", mon_edges, 0);
    rd(2'd0, d); chk("R6 blocked write leaves rx", d, 8'h5A);
    chk("R4 data read without status keeps flag", irq, 1'b1);
    rd(2'd2, d);
    wr(2'd0, 8'h96);
    wait_cyc(1);
    chk("R4 master write keeps flag", irq, 1'b1);
    wait_cyc(100);
    chk("R6 write after status read runs", mon_byte, 8'h96);
    rd(2'd0, d);
    chk("R4 new byte needs fresh status read", irq, 1'b1);
    rd(2'd2, d);
    rd(2'd0, d); chk("R2 second byte", d, 8'h96);
    chk("R4 flag cleared after handshake", irq, 1'b0);

    // interrupt gating
    irq_mask = 1'b1;
    wr(2'd0, 8'h24);
    wait_cyc(100);
    chk("R3 mask blocks irq", irq, 1'b0);
    rd(2'd2, d); chk("R3 flag set under mask", d[7], 1'b1);
    irq_mask = 1'b0;
    #1 chk("R3 unmask raises irq", irq, 1'b1);
    wr(2'd1, cval(1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
    #1 chk("R3 enable bit clear", irq, 1'b0);
    rd(2'd2, d); rd(2'd0, d);
    rd(2'd2, d); chk("R4 cleared", d[7], 1'b0);

    // slave, phase 0, select per byte
    wr(2'd1, cval(1'b0, 1'b1, 1'b0, 1'b0, 2'd0));
    sck_in = 1'b0;
    wr(2'd0, 8'hB4);
    wait_cyc(4);
    ss_n_in = 1'b0;
    slave_bits(1'b0, 1'b0, 8'h2D, 8, m1);
    wait_cyc(4); ss_n_in = 1'b1; wait_cyc(6);
    chk("R9 slave miso byte", m1, 8'hB4);
    chk("R2 slave flag irq", irq, 1'b1);
    rd(2'd0, d); chk("R9 slave rx byte", d, 8'h2D);
    chk("R5 data read alone keeps flag", irq, 1'b1);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h11);
    wait_cyc(1);
    chk("R5 status access then write clears", irq, 1'b0);

    // slave, phase 1, polarity 1, select held low over two bytes
    wr(2'd1, cval(1'b0, 1'b1, 1'b1, 1'b1, 2'd0));
    sck_in = 1'b1;
    wr(2'd0, 8'h6E);
    wait_cyc(4);
    ss_n_in = 1'b0;
    fork
      begin
        slave_bits(1'b1, 1'b1, 8'hC5, 8, m1);
        slave_bits(1'b1, 1'b1, 8'h1F, 8, m2);
      end
      begin
        wait_cyc(40);
        wr(2'd0, 8'h93);
      end
    join
    wait_cyc(6);
    ss_n_in = 1'b1;
    chk("R10 first continuous byte", m1, 8'h6E);
    chk("R10 reloaded second byte", m2, 8'h93);
    rd(2'd2, d); chk("R2 flag after slave bytes", d[7], 1'b1);
    rd(2'd0, d); chk("R9 second rx byte", d, 8'h1F);
    chk("R5 status then data read clears", irq, 1'b0);

    // slave, select dropped in the middle of a byte
    wr(2'd1, cval(1'b0, 1'b1, 1'b0, 1'b0, 2'd0));
    sck_in = 1'b0;
    wr(2'd0, 8'hE7);
    wait_cyc(4);
    ss_n_in = 1'b0;
    slave_bits(1'b0, 1'b0, 8'hFF, 3, m1);
    ss_n_in = 1'b1;
    wait_cyc(10);
    chk("R10 partial byte raises no flag", irq, 1'b0);
    ss_n_in = 1'b0;
    slave_bits(1'b0, 1'b0, 8'h42, 8, m1);
    wait_cyc(4); ss_n_in = 1'b1; wait_cyc(6);
    chk("R10 reload after abort", m1, 8'hE7);
    rd(2'd2, d);
    rd(2'd0, d); chk("R10 byte after abort", d, 8'h42);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule